// File: doc/BRIEF.md
# Chainable Presettable Binary Up-Counter

This block is a synchronous binary up-counter built from identical 4-bit slices, so that a counter of any width in steps of four bits is a single parameter away. Every slice reacts only on the rising clock edge. On each edge it takes one of four actions: it clears, it presets from a data word, it adds one, or it holds. A clear has priority over a preset, and a preset has priority over counting.

Counting needs two enables. The parallel enable is shared by every slice. The trickle enable enters the lowest slice and is forwarded upward: each slice's terminal-count output, which is its trickle enable ANDed with "all ones", becomes the trickle enable of the slice above it. The last slice's terminal count leaves the block, so that two of these counters can also be chained into one.

A parameter can shorten the counting range to a modulus. When counting is enabled, a decoder watches for the last state of the range and turns the next increment into a clear. This gives a clean wrap with no intermediate state. The block also has an asynchronous active-low reset. It asserts at once, and its release is re-timed through two flops before it reaches the counting registers.

Top module: `cnt_cascade`

## Requirements
- R1: While `rst_n` is low, `count` is 0 with no clock edge needed. After `rst_n` rises, the first two rising edges leave `count` at 0 whatever the other inputs are, and the third edge is the first that can change it.
- R2: When `clr_n` is low at a rising edge, `count` becomes 0 whatever `load_n`, `cnt_en_p` and `cnt_en_t` are.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `load_data` whatever the two count enables are.
- R4: When `clr_n`, `load_n`, `cnt_en_p` and `cnt_en_t` are all high at a rising edge, `count` increases by one. In full-range mode it wraps from all ones to 0.
- R5: When `clr_n` and `load_n` are high and either count enable is low, `count` keeps its value across the edge.
- R6: `term_cnt` is high exactly when `cnt_en_t` is high and every bit of `count` is 1. It follows `cnt_en_t` in the same cycle, with no clock edge in between.
- R7: The slices are chained so that a slice advances only when every lower slice is at 15 and `cnt_en_t` is high. When the counter runs freely, `term_cnt` is high for exactly one clock period out of every 2^(4·N_SLICES) periods, and `count` is 0 on the edge that follows that period.
- R8: With `MODULUS` nonzero, a rising edge with `count` equal to `MODULUS-1`, both enables high and `load_n` high takes `count` to 0. A low `load_n` at that value still presets instead. `MODULUS` = 10 gives a decade counter 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release re-timed internally |
| clr_n | input | 1 | Synchronous active-low clear, highest priority |
| load_n | input | 1 | Synchronous active-low preset from `load_data` |
| load_data | input | 4·N_SLICES | Preset value |
| cnt_en_p | input | 1 | Parallel count enable, common to all slices |
| cnt_en_t | input | 1 | Trickle count enable into the lowest slice, also gates `term_cnt` |
| count | output | 4·N_SLICES | Current count |
| term_cnt | output | 1 | Terminal count of the highest slice |

## Verification
Assertions in the slice check the four-way priority on every cycle: clear to zero, preset to the data, increment and hold. Assertions at the top check that the terminal count only rises at all ones with the trickle enable high, that it is always followed by a wrap to zero while counting, and, in a shortened build, that the decoded value always wraps. Only the bench's scenarios can show the full ordering of all 256 states of a two-slice counter, the exact cycle on which counting resumes after reset is released, the same-cycle response of the terminal count to the trickle enable, and a decade counter that stays inside 0..9 while sharing its inputs with a full-range counter.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int SLICE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_CLR  = 2'd1,
    OP_LOAD = 2'd2,
    OP_INC  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int SW = SLICE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic [SW-1:0] d,
  input  logic          en_p,
  input  logic          en_t,
  output logic [SW-1:0] q,
  output logic          tc
);
  localparam logic [SW-1:0] ALL_ONES = {SW{1'b1}};

  cnt_op_e       op;
  logic [SW-1:0] q_r;
  logic [SW-1:0] q_nxt;
  logic          q_en;

  // priority decode: clear, then preset, then count
  always_comb begin
    if (!clr_n)              op = OP_CLR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_INC;
    else                     op = OP_HOLD;
  end

  always_comb begin
    q_en  = 1'b1;
    q_nxt = q_r;
    unique case (op)
      OP_CLR:  q_nxt = '0;
      OP_LOAD: q_nxt = d;
      OP_INC:  q_nxt = q_r + 1'b1;
      default: q_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = en_t && (q_r == ALL_ONES);

  a_r2_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));

  a_r3_load_data : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (q == $past(d)));

  a_r4_increment : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> (q == SW'($past(q) + 1'b1)));

  a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cnt_mod_decode.sv
module cnt_mod_decode #(
  parameter int W       = 8,
  parameter int MODULUS = 0
) (
  input  logic [W-1:0] count,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  output logic         clr_eff_n
);
  generate
    if (MODULUS == 0) begin : g_full
      assign clr_eff_n = clr_n;
    end else begin : g_short
      localparam logic [W-1:0] LAST = W'(MODULUS - 1);
      logic at_last;
      assign at_last   = (count == LAST) && en_p && en_t && load_n;
      assign clr_eff_n = clr_n && !at_last;
    end
  endgenerate
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade
  import cnt_pkg::*;
#(
  parameter int N_SLICES = 2,
  parameter int MODULUS  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic [N_SLICES*SLICE_W-1:0] load_data,
  input  logic                        cnt_en_p,
  input  logic                        cnt_en_t,
  output logic [N_SLICES*SLICE_W-1:0] count,
  output logic                        term_cnt
);
  localparam int W = N_SLICES * SLICE_W;

  logic          rst_q_n;
  logic          clr_eff_n;
  logic [N_SLICES:0] trickle;
  logic [W-1:0]  count_w;

  cnt_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cnt_mod_decode #(.W(W), .MODULUS(MODULUS)) u_mod (
    .count     (count_w),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_p      (cnt_en_p),
    .en_t      (cnt_en_t),
    .clr_eff_n (clr_eff_n)
  );

  assign trickle[0] = cnt_en_t;

  generate
    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
      cnt_slice #(.SW(SLICE_W)) u_slice (
        .clk    (clk),
        .rst_n  (rst_q_n),
        .clr_n  (clr_eff_n),
        .load_n (load_n),
        .d      (load_data[i*SLICE_W +: SLICE_W]),
        .en_p   (cnt_en_p),
        .en_t   (trickle[i]),
        .q      (count_w[i*SLICE_W +: SLICE_W]),
        .tc     (trickle[i+1])
      );
    end
  endgenerate

  assign count    = count_w;
  assign term_cnt = trickle[N_SLICES];

  a_r6_tc_at_max : assert property (@(posedge clk) disable iff (!rst_q_n)
    term_cnt |-> (cnt_en_t && (count == {W{1'b1}})));

  a_r7_wrap_after_tc : assert property (@(posedge clk) disable iff (!rst_q_n)
    (term_cnt && cnt_en_p && load_n) |=> (count == '0));

  generate
    if (MODULUS != 0) begin : g_mod_chk
      a_r8_mod_wrap : assert property (@(posedge clk) disable iff (!rst_q_n)
        ((count == W'(MODULUS - 1)) && cnt_en_p && cnt_en_t && load_n)
          |=> (count == '0));
    end
  endgenerate
endmodule

// File: tb/test_cnt_cascade.sv
module test_cnt_cascade;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_n, load_n, en_p, en_t;
  logic [7:0] ld;
  logic [7:0] cnt, cnt_m;
  logic       tc, tc_m;

  int n_chk = 0;
  int n_fail = 0;
  int exp_a = 0;
  int exp_m = 0;

  always #2.5 clk = ~clk;

  cnt_cascade #(.N_SLICES(2), .MODULUS(0)) i_cnt_cascade (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .load_data(ld), .cnt_en_p(en_p), .cnt_en_t(en_t),
    .count(cnt), .term_cnt(tc)
  );

  cnt_cascade #(.N_SLICES(2), .MODULUS(10)) i_cnt_cascade_mod10 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .load_data(ld), .cnt_en_p(en_p), .cnt_en_t(en_t),
    .count(cnt_m), .term_cnt(tc_m)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one clock with given inputs; model both counters, then check outputs
  task automatic step(input string req, input logic c, input logic l,
                      input logic [7:0] d, input logic p, input logic t);
    clr_n = c; load_n = l; ld = d; en_p = p; en_t = t;
    #0.5;
    chk({req, " term_cnt before edge"}, int'(tc), int'(t && exp_a == 255));
    if (!c)          begin exp_a = 0; exp_m = 0; end
    else if (!l)     begin exp_a = d; exp_m = d; end
    else if (p && t) begin
      exp_a = (exp_a + 1) % 256;
      exp_m = (exp_m == 9) ? 0 : (exp_m + 1) % 256;
    end
    @(posedge clk); #1;
    chk({req, " count"}, int'(cnt), exp_a);
    chk({req, " mod10 count"}, int'(cnt_m), exp_m);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr_n = 1; load_n = 1; ld = 0; en_p = 1; en_t = 1;
    #1;
    chk("R1 async reset count", int'(cnt), 0);
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 first edge after release", int'(cnt), 0);
    @(posedge clk); #1;
    chk("R1 second edge after release", int'(cnt), 0);
    @(posedge clk); #1;
    chk("R1 third edge counts", int'(cnt), 1);
    exp_a = 1; exp_m = 1;
    // reset mid-count asserts at once
    step("R4 pre", 1, 1, 0, 1, 1);
    rst_n = 1'b0; #0.5;
    chk("R1 reset mid-run", int'(cnt), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1; exp_a = 0; exp_m = 0;
  endtask

  task automatic t_sweep();
    int tc_hi = 0;
    step("R2 clear", 0, 1, 0, 1, 1);
    for (int i = 0; i < 256; i++) begin
      if (exp_a == 255) tc_hi++;
      step("R4 R7 sweep", 1, 1, 0, 1, 1);
    end
    chk("R7 one terminal period per 256", tc_hi, 1);
    chk("R7 wrapped to start", int'(cnt), 0);
  endtask

  task automatic t_hold_tc();
    step("R3 load 255", 1, 0, 8'hFF, 0, 0);
    step("R5 hold en_p low", 1, 1, 0, 0, 1);
    step("R5 hold en_t low", 1, 1, 0, 1, 0);
    en_t = 1'b0; #0.5;
    chk("R6 term_cnt low with en_t low", int'(tc), 0);
    en_t = 1'b1; #0.5;
    chk("R6 term_cnt same cycle", int'(tc), 1);
    step("R4 wrap 255->0", 1, 1, 0, 1, 1);
    step("R3 load 15", 1, 0, 8'h0F, 0, 0);
    step("R7 carry into upper slice", 1, 1, 0, 1, 1);
    chk("R7 upper slice", int'(cnt), 16);
    step("R3 load 31", 1, 0, 8'h1F, 0, 0);
    step("R7 no carry with en_t low", 1, 1, 0, 1, 0);
  endtask

  task automatic t_priority();
    step("R3 load 8'hA5", 1, 0, 8'hA5, 0, 0);
    step("R3 load over enables", 1, 0, 8'h3C, 1, 1);
    step("R2 clear over load", 0, 0, 8'h77, 1, 1);
    step("R3 load", 1, 0, 8'hC3, 1, 0);
    step("R2 clear with enables low", 0, 1, 0, 0, 0);
  endtask

  task automatic t_mod10();
    step("R8 clear", 0, 1, 0, 1, 1);
    for (int i = 0; i < 25; i++) step("R8 decade run", 1, 1, 0, 1, 1);
    chk("R8 inside decade", int'(cnt_m < 10), 1);
    step("R8 load 9", 1, 0, 8'd9, 0, 0);
    step("R8 hold at 9", 1, 1, 0, 0, 1);
    step("R8 load wins at 9", 1, 0, 8'd5, 1, 1);
    step("R8 load 9 again", 1, 0, 8'd9, 0, 0);
    step("R8 wrap 9->0", 1, 1, 0, 1, 1);
    chk("R8 mod count zero", int'(cnt_m), 0);
    chk("R8 mod term_cnt idle", int'(tc_m), 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_sweep();
    t_hold_tc();
    t_priority();
    t_mod10();
    report();
  end
endmodule